// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with One Compare Channel

This block is an 8-bit counter with one compare register and one waveform output. A processor reaches it through a small register port with four byte-wide locations: control, compare value, count and flags. The control byte picks one of four counting modes. Free-running counting wraps at 0xFF. Clear-on-match counting restarts at zero after the count reaches the compare value. Fast PWM is a single-slope sawtooth. Phase-correct PWM counts up to 0xFF and back down to zero. The control byte also sets the action the compare output takes on a match.

There is no prescaler inside the block. An external count-enable input marks the cycles on which the counter may advance. The clock-select field of the control byte only gates counting on or off. The block drives the compare output and a pin-override enable, and keeps overflow and compare-match flags that software clears by writing ones. In the PWM modes, writes to the compare register are double-buffered and reach the comparator only at a mode-specific point in the cycle.

Top module: `pwm_timer8`

## Requirements
- R1: After reset every register reads 0x00, and the compare output, the override enable and both flags are low.
- R2: The count changes only on a cycle where `cnt_en` is high and the clock-select field (control bits 2:0) is nonzero. A write to the count register (address 2) is the exception.
- R3: The mode code is {control bit 3, control bit 6}: 00 free-running, 01 phase-correct PWM, 10 clear-on-match, 11 fast PWM. In free-running mode each tick adds one, and 0xFF wraps to 0x00.
- R4: In clear-on-match mode, a tick at which the count equals the compare value loads zero. On a match in this mode and in free-running mode, compare-output code (control bits 5:4) 01 toggles the output, 10 drives it low and 11 drives it high.
- R5: The overflow flag (flags register address 3, bit 0) is set by a tick at count 0xFF in free-running, clear-on-match and fast PWM modes. In phase-correct mode it is set only by the tick that turns the counter upward at zero, and not at 0xFF.
- R6: The compare flag (flags bit 1) is set by every compare match in any mode. Writing 1 to a flag bit clears that flag, and a new event in the same cycle wins over the clear.
- R7: A compare write (address 1) reads back at once. It reaches the comparator at once in the two non-PWM modes. In fast PWM it waits for the wrap from 0xFF. In phase-correct mode it waits for the tick at 0xFF.
- R8: In fast PWM, code 10 drives the output low on a match and high at the wrap, and code 11 does the opposite. When both happen on one tick, the wrap action wins. Code 01 leaves the output alone.
- R9: Phase-correct mode counts 0 up to 0xFF, then 0xFE down to 0, then up again. Code 10 drives the output low on an upward match and high on a downward match, and code 11 does the opposite.
- R10: Writing the control byte with bit 7 set, in a non-PWM mode, applies the action of the written compare-output code at once. It sets no flag and does not change the count. In PWM modes bit 7 has no effect. Bit 7 always reads 0.
- R11: After a write to the count register, the next tick produces no compare match.
- R12: `pin_ovr` is high exactly when the compare-output code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Counting strobe from an external prescaler |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 compare, 2 count, 3 flags |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| wave_out | output | 1 | Compare output |
| pin_ovr | output | 1 | Compare output replaces port data when high |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare-match flag |

## Verification
The hardest case is the double-buffered compare value in the PWM modes. A compare write made mid-cycle must stay invisible until the wrap or the top turn, so the stale and the new values have to produce different output edges. The stimulus writes a new compare value after the current match has passed. It then runs a full lap and checks the output at counts where only the new value, or only the old value, would cause an action. Phase-correct mode needs over 500 ticks to reach its bottom overflow. The bench jumps the count with register writes where possible and steps one tick at a time around each event.

// File: rtl/pwm_timer8.sv
module pwm_timer8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_en,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       wave_out,
  output logic       pin_ovr,
  output logic       ovf_flag,
  output logic       cmp_flag
);

  localparam logic [1:0] MD_NORM = 2'b00;
  localparam logic [1:0] MD_PC   = 2'b01;
  localparam logic [1:0] MD_CTC  = 2'b10;
  localparam logic [1:0] MD_FAST = 2'b11;
  localparam logic [7:0] MAXV    = 8'hFF;

  logic [7:0] ctl, ocr_buf, ocr_act, cnt, cnt_nx;
  logic       dn, blk, out_q, out_nx;

  wire [1:0] mode   = {ctl[3], ctl[6]};
  wire [1:0] com    = ctl[5:4];
  wire       pwm    = ctl[6];
  wire       tick   = cnt_en && (ctl[2:0] != 3'd0);
  wire       wr_ctl = reg_we && (reg_addr == 2'd0);
  wire       wr_ocr = reg_we && (reg_addr == 2'd1);
  wire       wr_cnt = reg_we && (reg_addr == 2'd2);
  wire       wr_flg = reg_we && (reg_addr == 2'd3);
  wire [7:0] ocr_eff = pwm ? ocr_act : ocr_buf;
  wire       at_max  = (cnt == MAXV);
  wire       at_bot  = (cnt == 8'h00);
  wire       match   = tick && !blk && (cnt == ocr_eff);
  wire       turn_dn = (mode == MD_PC) && !dn && at_max;
  wire       turn_up = (mode == MD_PC) && dn && at_bot;
  wire       ovf_evt = tick && ((mode == MD_PC) ? turn_up : at_max);
  wire       wrap    = tick && (mode == MD_FAST) && at_max;
  wire       force_ok = wr_ctl && reg_wdata[7] && !reg_wdata[6];

  always_comb begin
    case (mode)
      MD_PC:   cnt_nx = dn ? (at_bot ? 8'h01 : cnt - 8'h01)
                           : (at_max ? 8'hFE : cnt + 8'h01);
      MD_CTC:  cnt_nx = match ? 8'h00 : cnt + 8'h01;
      default: cnt_nx = cnt + 8'h01;
    endcase
  end

  always_comb begin
    out_nx = out_q;
    if (force_ok) begin
      case (reg_wdata[5:4])
        2'b01:   out_nx = ~out_q;
        2'b10:   out_nx = 1'b0;
        2'b11:   out_nx = 1'b1;
        default: out_nx = out_q;
      endcase
    end else if (tick) begin
      case (mode)
        MD_NORM, MD_CTC: begin
          if (match) begin
            case (com)
              2'b01:   out_nx = ~out_q;
              2'b10:   out_nx = 1'b0;
              2'b11:   out_nx = 1'b1;
              default: out_nx = out_q;
            endcase
          end
        end
        MD_FAST: begin
          if (match && com[1]) out_nx = com[0];
          if (at_max && com[1]) out_nx = ~com[0];
        end
        default: begin
          if (match && com[1]) out_nx = dn ? ~com[0] : com[0];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl      <= 8'h00;
      ocr_buf  <= 8'h00;
      ocr_act  <= 8'h00;
      cnt      <= 8'h00;
      dn       <= 1'b0;
      blk      <= 1'b0;
      out_q    <= 1'b0;
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (wr_ctl) ctl <= {1'b0, reg_wdata[6:0]};
      if (wr_ocr) ocr_buf <= reg_wdata;
      if (!pwm || wrap || (tick && turn_dn)) ocr_act <= ocr_buf;

      if (wr_cnt) cnt <= reg_wdata;
      else if (tick) cnt <= cnt_nx;

      if (wr_cnt) blk <= 1'b1;
      else if (tick) blk <= 1'b0;

      if (mode != MD_PC) dn <= 1'b0;
      else if (tick && !wr_cnt) begin
        if (turn_dn) dn <= 1'b1;
        else if (turn_up) dn <= 1'b0;
      end

      out_q <= out_nx;

      if (ovf_evt) ovf_flag <= 1'b1;
      else if (wr_flg && reg_wdata[0]) ovf_flag <= 1'b0;
      if (match) cmp_flag <= 1'b1;
      else if (wr_flg && reg_wdata[1]) cmp_flag <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = ctl;
      2'd1:    reg_rdata = ocr_buf;
      2'd2:    reg_rdata = cnt;
      default: reg_rdata = {6'b0, cmp_flag, ovf_flag};
    endcase
  end

  assign wave_out = out_q;
  assign pin_ovr  = (com != 2'b00);

endmodule

// File: rtl/pwm_timer8_chk.sv
module pwm_timer8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cnt_en,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic [7:0] ctl,
  input logic [7:0] cnt,
  input logic       ovf_flag,
  input logic       cmp_flag,
  input logic       pin_ovr
);

  wire tick_ok = cnt_en && (ctl[2:0] != 3'd0);
  wire cnt_wr  = reg_we && (reg_addr == 2'd2);

  AST_TIMER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_ok && !cnt_wr) |=> $stable(cnt)); // R2

  AST_NORMAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ok && !ctl[6] && !ctl[3] && !cnt_wr) |=> (cnt == $past(cnt) + 8'd1)); // R3

  AST_PC_OVF_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_flag) && $past(ctl[6]) && !$past(ctl[3])) |-> ($past(cnt) == 8'h00)); // R5

  AST_OVF_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_flag) && !($past(ctl[6]) && !$past(ctl[3]))) |-> ($past(cnt) == 8'hFF)); // R5

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd3 && reg_wdata[1:0] == 2'b11 && !cnt_en) |=> (!ovf_flag && !cmp_flag)); // R6

  AST_FORCE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0 && reg_wdata[7] && !cnt_en && !cmp_flag) |=> !cmp_flag); // R10

  AST_OVR_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 2'd0) |=> (pin_ovr == ($past(reg_wdata[5:4]) != 2'b00))); // R12

endmodule

bind pwm_timer8 pwm_timer8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .ctl(ctl), .cnt(cnt),
  .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .pin_ovr(pin_ovr)
);

// File: tb/sim_pwm_timer8.sv
`timescale 1ns/1ps
module sim_pwm_timer8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic       reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       wave_out, pin_ovr, ovf_flag, cmp_flag;
  int nvec = 0;
  int nbad = 0;

  pwm_timer8 u0 (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wave_out(wave_out), .pin_ovr(pin_ovr), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 register reset", v, 0);
    end
    chk("R1 output reset", wave_out, 0);
    chk("R1 override reset", pin_ovr, 0);
  endtask

  task automatic t_gate;
    logic [7:0] v;
    wr(0, 8'h00);
    tick(5);
    rd(2, v); chk("R2 clock select zero stops", v, 0);
    wr(0, 8'h01);
    tick(5);
    rd(2, v); chk("R2 counts enabled ticks", v, 5);
    repeat (4) @(negedge clk);
    rd(2, v); chk("R2 idle without cnt_en", v, 5);
  endtask

  task automatic t_wrap;
    logic [7:0] v;
    wr(3, 8'h03);
    wr(2, 8'hFD);
    tick(2);
    rd(2, v); chk("R3 count before wrap", v, 8'hFF);
    chk("R5 no overflow before max tick", ovf_flag, 0);
    tick(1);
    rd(2, v); chk("R3 wrap to zero", v, 0);
    chk("R5 overflow at max", ovf_flag, 1);
    wr(3, 8'h01);
    rd(3, v); chk("R6 write-one clears", v, 0);
  endtask

  task automatic t_ctc;
    logic [7:0] v;
    wr(1, 8'h05);
    wr(2, 8'h00);
    wr(0, 8'h19);
    tick(5);
    rd(2, v); chk("R4 count at compare", v, 5);
    chk("R4 output before match", wave_out, 0);
    tick(1);
    rd(2, v); chk("R4 clear on match", v, 0);
    chk("R4 toggle on match", wave_out, 1);
    chk("R6 compare flag set", cmp_flag, 1);
    tick(6);
    chk("R4 second toggle", wave_out, 0);
    chk("R5 no overflow below max in clear-on-match", ovf_flag, 0);
  endtask

  task automatic t_force;
    logic [7:0] v;
    wr(3, 8'h03);
    wr(0, 8'hB9);
    chk("R10 force set", wave_out, 1);
    chk("R10 no flag", cmp_flag, 0);
    rd(2, v); chk("R10 count untouched", v, 0);
    rd(0, v); chk("R10 strobe reads zero", v, 8'h39);
    wr(0, 8'hA9);
    chk("R10 force clear", wave_out, 0);
  endtask

  task automatic t_block;
    logic [7:0] v;
    wr(0, 8'h11);
    wr(1, 8'h03);
    wr(3, 8'h03);
    wr(2, 8'h03);
    tick(1);
    rd(2, v); chk("R11 count advanced", v, 4);
    chk("R11 blocked match output", wave_out, 0);
    chk("R11 blocked match flag", cmp_flag, 0);
    wr(2, 8'h02);
    tick(2);
    chk("R11 later match acts", wave_out, 1);
    chk("R6 later match flag", cmp_flag, 1);
  endtask

  task automatic t_fast;
    logic [7:0] v;
    wr(1, 8'h40);
    wr(3, 8'h03);
    wr(0, 8'h69);
    chk("R12 override on", pin_ovr, 1);
    wr(2, 8'hFF);
    tick(1);
    chk("R5 overflow at fast wrap", ovf_flag, 1);
    chk("R8 high after wrap", wave_out, 1);
    wr(1, 8'h80);
    rd(1, v); chk("R7 compare reads back", v, 8'h80);
    tick(8'h40);
    chk("R8 high before match", wave_out, 1);
    tick(1);
    chk("R7 old compare still active", wave_out, 0);
    tick(8'hBE);
    rd(2, v); chk("R8 count at max", v, 8'hFF);
    tick(1);
    chk("R8 set at wrap", wave_out, 1);
    tick(8'h41);
    chk("R7 old value gone after wrap", wave_out, 1);
    tick(8'h3F);
    chk("R7 high before new compare", wave_out, 1);
    tick(1);
    chk("R8 clear at new compare", wave_out, 0);
    wr(0, 8'hF9);
    chk("R10 force ignored in PWM", wave_out, 0);
    wr(0, 8'h01);
    chk("R12 override off", pin_ovr, 0);
  endtask

  task automatic t_pc;
    logic [7:0] v;
    wr(0, 8'h31);
    wr(1, 8'h10);
    wr(0, 8'hB1);
    chk("R10 force set before phase test", wave_out, 1);
    wr(2, 8'h00);
    wr(0, 8'h61);
    wr(3, 8'h03);
    tick(8'h10);
    chk("R9 high before upward match", wave_out, 1);
    tick(1);
    chk("R9 low after upward match", wave_out, 0);
    wr(1, 8'h20);
    tick(8'hEE);
    rd(2, v); chk("R9 reaches top", v, 8'hFF);
    chk("R5 no overflow at top in phase mode", ovf_flag, 0);
    tick(1);
    rd(2, v); chk("R9 turns down", v, 8'hFE);
    tick(8'hDE);
    rd(2, v); chk("R9 descending count", v, 8'h20);
    chk("R9 still low before downward match", wave_out, 0);
    tick(1);
    chk("R7 new compare taken at top", wave_out, 1);
    tick(8'h1F);
    rd(2, v); chk("R9 reaches bottom", v, 0);
    chk("R5 no overflow before bottom tick", ovf_flag, 0);
    tick(1);
    rd(2, v); chk("R9 turns up", v, 1);
    chk("R5 overflow at bottom", ovf_flag, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_gate;
    t_wrap;
    t_ctc;
    t_force;
    t_block;
    t_fast;
    t_pc;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nvec++;
    nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule